// File: doc/BRIEF.md
# SDRAM Write-Burst Interrupt Sequencer

This block sits on the controller side of an SDRAM interface. It issues a write burst and then ends it early in one of two ways. In the read path, a READ follows the last wanted write word and ends the burst. In the precharge path, a bank precharge or a precharge of all banks ends the burst after a write-recovery gap, and an ACTIVATE of the same bank follows once the row-precharge time has passed. The sequencer drives the command lines, bank and address, the enable for the controller's DQ drivers, and the byte masks.

A request is taken when `req_valid_i` and `req_ready_o` are both high at a clock edge. It carries the kind of interrupt, the bank, the write and read columns, the row to reopen, and the number of wanted write words. The CAS latency, the write-recovery count and the row-precharge count are sampled with the request. Every cycle in which no command is due carries a NOP. All counts are in clock cycles, and cycle 0 is the cycle in which the WRITE appears.

Top module: `sdram_wr_intr_seq`

## Requirements
- R1: In the cycle after a request is accepted, the block issues WRITE with the request bank and with the write column, zero-extended, on the address lines.
- R2: For a read request (`req_kind_i`=0), READ is issued in cycle L, the cycle right after the last wanted word. Here L is the clamped word count. The read column is on the address lines and the request bank is on the bank lines.
- R3: `dq_oe_o` is high in cycles 0 to L-1 and low from cycle L onward. This leaves the bus idle for at least one cycle before read data arrives, CAS-latency cycles after the READ.
- R4: After a READ, the block holds NOP and stays busy until cycle L+CL+BURST-1, the cycle of the last read word.
- R5: For a precharge request (`req_kind_i`=1), PRECHARGE is issued in cycle L-1+M, where M is the write-recovery count. Address bit 10 equals `req_all_i` and all other address bits are zero.
- R6: When L is below the burst length of 4 on a precharge request, every DQM bit is high from cycle L through the PRECHARGE cycle. In every other case DQM stays low.
- R7: ACTIVATE with the request bank and row follows the PRECHARGE after exactly T cycles, where T is the row-precharge count. The sequence ends on the ACTIVATE.
- R8: The block clamps its inputs before use. A word count of 0 is used as 1 and a count above 4 is used as 4. A CAS latency of 0 is used as 1. A write-recovery or row-precharge count of 0 is used as 1.
- R9: Commands are encoded as {RAS#,CAS#,WE#}: NOP=111, ACTIVATE=011, READ=101, WRITE=100, PRECHARGE=010. Every cycle that carries no other command is NOP, with bank and address zero.
- R10: `req_ready_o` is low from the WRITE through the last cycle of the sequence and goes high in the next cycle. A request presented while ready is low has no effect.
- R11: While reset is active and after it is released, the block is ready, drives NOP, and holds DQ enable and DQM low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat_i | input | 2 | CAS latency, 1 to 3 |
| wr_rec_i | input | 3 | Write-recovery cycles M |
| trp_i | input | 3 | Row-precharge cycles T |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready for a request |
| req_kind_i | input | 1 | 0 = read interrupt, 1 = precharge interrupt |
| req_all_i | input | 1 | Precharge all banks |
| req_bank_i | input | 2 | Bank |
| req_wcol_i | input | 8 | Write column |
| req_rcol_i | input | 8 | Read column |
| req_row_i | input | 12 | Row for the ACTIVATE |
| req_len_i | input | 3 | Wanted write words |
| cmd_o | output | 3 | {RAS#,CAS#,WE#} |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Address lines |
| dq_oe_o | output | 1 | Controller DQ drive enable |
| dqm_o | output | 2 | Byte masks |

## Verification
Two events can share a cycle. When the write-recovery count is 1, the PRECHARGE lands in the first masked cycle. With a one-word read request, the READ lands directly after the WRITE, so the bus turns around at once. The bench provokes both cases. It also holds a request valid across a sequence so that the next one starts in the cycle after ready returns. A behavioural model compares command, address, DQ enable, DQM and ready in every cycle.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_PRE = 3'b010,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sdw_cmd_e;

  typedef enum logic {
    KIND_RD  = 1'b0,
    KIND_PRE = 1'b1
  } sdw_kind_e;
endpackage

// File: rtl/sdw_phase_cnt.sv
module sdw_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sdw_sched.sv
// Derives the cycle offsets of each event from the latched request.
module sdw_sched #(
  parameter int BURST = 4,
  parameter int LEN_W = 3,
  parameter int CFG_W = 3,
  parameter int PH_W  = 5
) (
  input  logic             kind,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       cl,
  input  logic [CFG_W-1:0] m,
  input  logic [CFG_W-1:0] trp,
  output logic [PH_W-1:0]  t_rd,
  output logic [PH_W-1:0]  t_pre,
  output logic [PH_W-1:0]  t_act,
  output logic [PH_W-1:0]  t_last,
  output logic             mask_en
);
  import sdw_pkg::*;

  always_comb begin
    t_rd    = PH_W'(len);
    t_pre   = PH_W'(len) + PH_W'(m) - PH_W'(1);
    t_act   = t_pre + PH_W'(trp);
    if (kind == KIND_RD) t_last = PH_W'(len) + PH_W'(cl) + PH_W'(BURST - 1);
    else                 t_last = t_act;
    mask_en = (kind == KIND_PRE) && (PH_W'(len) < PH_W'(BURST));
  end
endmodule

// File: rtl/sdw_cmd_drv.sv
// Turns the phase and schedule into bus values.
module sdw_cmd_drv #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  parameter int LEN_W  = 3,
  parameter int DQM_W  = 2,
  parameter int PH_W   = 5
) (
  input  logic              busy,
  input  logic [PH_W-1:0]   phase,
  input  logic              kind,
  input  logic              all,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  wcol,
  input  logic [COL_W-1:0]  rcol,
  input  logic [ROW_W-1:0]  row,
  input  logic [LEN_W-1:0]  len,
  input  logic [PH_W-1:0]   t_rd,
  input  logic [PH_W-1:0]   t_pre,
  input  logic [PH_W-1:0]   t_act,
  input  logic              mask_en,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              dq_oe,
  output logic [DQM_W-1:0]  dqm
);
  import sdw_pkg::*;

  logic in_data, in_gap;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (busy) begin
      if (phase == '0) begin
        cmd  = CMD_WR;
        ba   = bank;
        addr = ROW_W'(wcol);
      end else if (kind == KIND_RD && phase == t_rd) begin
        cmd  = CMD_RD;
        ba   = bank;
        addr = ROW_W'(rcol);
      end else if (kind == KIND_PRE && phase == t_pre) begin
        cmd          = CMD_PRE;
        ba           = bank;
        addr[AP_BIT] = all;
      end else if (kind == KIND_PRE && phase == t_act) begin
        cmd  = CMD_ACT;
        ba   = bank;
        addr = row;
      end
    end
  end

  assign in_data = busy && (phase < PH_W'(len));
  assign in_gap  = busy && mask_en && (phase >= PH_W'(len)) && (phase <= t_pre);
  assign dq_oe   = in_data;

  generate
    for (genvar g = 0; g < DQM_W; g++) begin : g_lane
      assign dqm[g] = in_gap;
    end
  endgenerate
endmodule

// File: rtl/sdram_wr_intr_seq.sv
module sdram_wr_intr_seq
  import sdw_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  parameter int BURST  = 4,
  parameter int CFG_W  = 3,
  parameter int DQM_W  = 2,
  parameter int LEN_W  = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat_i,
  input  logic [CFG_W-1:0]  wr_rec_i,
  input  logic [CFG_W-1:0]  trp_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_kind_i,
  input  logic              req_all_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_wcol_i,
  input  logic [COL_W-1:0]  req_rcol_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              dq_oe_o,
  output logic [DQM_W-1:0]  dqm_o
);
  localparam int PH_W = $clog2(BURST + 2 * (1 << CFG_W) + 8);

  logic              busy_q, busy_d;
  logic              kind_q, kind_d;
  logic              all_q, all_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  wcol_q, wcol_d;
  logic [COL_W-1:0]  rcol_q, rcol_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [1:0]        cl_q, cl_d;
  logic [CFG_W-1:0]  m_q, m_d;
  logic [CFG_W-1:0]  trp_q, trp_d;

  logic              accept;
  logic [LEN_W-1:0]  len_c;
  logic [1:0]        cl_c;
  logic [CFG_W-1:0]  m_c, trp_c;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   t_rd, t_pre, t_act, t_last;
  logic              mask_en;

  assign accept      = req_valid_i && !busy_q;
  assign req_ready_o = !busy_q;

  // input clamping
  always_comb begin
    if (req_len_i == '0)                     len_c = LEN_W'(1);
    else if (req_len_i > LEN_W'(BURST))      len_c = LEN_W'(BURST);
    else                                     len_c = req_len_i;
    cl_c  = (cas_lat_i == 2'd0) ? 2'd1 : cas_lat_i;
    m_c   = (wr_rec_i == '0) ? CFG_W'(1) : wr_rec_i;
    trp_c = (trp_i == '0) ? CFG_W'(1) : trp_i;
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    all_d  = all_q;
    bank_d = bank_q;
    wcol_d = wcol_q;
    rcol_d = rcol_q;
    row_d  = row_q;
    len_d  = len_q;
    cl_d   = cl_q;
    m_d    = m_q;
    trp_d  = trp_q;
    if (accept) begin
      busy_d = 1'b1;
      kind_d = req_kind_i;
      all_d  = req_all_i;
      bank_d = req_bank_i;
      wcol_d = req_wcol_i;
      rcol_d = req_rcol_i;
      row_d  = req_row_i;
      len_d  = len_c;
      cl_d   = cl_c;
      m_d    = m_c;
      trp_d  = trp_c;
    end else if (busy_q && phase == t_last) begin
      busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      all_q  <= 1'b0;
      bank_q <= '0;
      wcol_q <= '0;
      rcol_q <= '0;
      row_q  <= '0;
      len_q  <= LEN_W'(1);
      cl_q   <= 2'd1;
      m_q    <= CFG_W'(1);
      trp_q  <= CFG_W'(1);
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      all_q  <= all_d;
      bank_q <= bank_d;
      wcol_q <= wcol_d;
      rcol_q <= rcol_d;
      row_q  <= row_d;
      len_q  <= len_d;
      cl_q   <= cl_d;
      m_q    <= m_d;
      trp_q  <= trp_d;
    end
  end

  sdw_phase_cnt #(.W(PH_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (busy_q),
    .q     (phase)
  );

  sdw_sched #(
    .BURST (BURST),
    .LEN_W (LEN_W),
    .CFG_W (CFG_W),
    .PH_W  (PH_W)
  ) u_sched (
    .kind    (kind_q),
    .len     (len_q),
    .cl      (cl_q),
    .m       (m_q),
    .trp     (trp_q),
    .t_rd    (t_rd),
    .t_pre   (t_pre),
    .t_act   (t_act),
    .t_last  (t_last),
    .mask_en (mask_en)
  );

  sdw_cmd_drv #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .AP_BIT (AP_BIT),
    .LEN_W  (LEN_W),
    .DQM_W  (DQM_W),
    .PH_W   (PH_W)
  ) u_drv (
    .busy    (busy_q),
    .phase   (phase),
    .kind    (kind_q),
    .all     (all_q),
    .bank    (bank_q),
    .wcol    (wcol_q),
    .rcol    (rcol_q),
    .row     (row_q),
    .len     (len_q),
    .t_rd    (t_rd),
    .t_pre   (t_pre),
    .t_act   (t_act),
    .mask_en (mask_en),
    .cmd     (cmd_o),
    .ba      (ba_o),
    .addr    (addr_o),
    .dq_oe   (dq_oe_o),
    .dqm     (dqm_o)
  );
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk
  import sdw_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int DQM_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ROW_W-1:0]  addr_o,
  input logic              dq_oe_o,
  input logic [DQM_W-1:0]  dqm_o
);
  a_r1_write_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_WR) |-> ($past(req_ready_o) && !req_ready_o && dq_oe_o));

  a_r2_read_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_RD) |-> ($past(dq_oe_o) && !dq_oe_o));

  a_r3_bus_released_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_RD) |=> !dq_oe_o);

  a_r6_mask_ends_on_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqm_o[0]) |-> ($past(cmd_o) == CMD_PRE));

  a_r6_mask_not_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm_o != '0) |-> !dq_oe_o);

  a_r7_activate_ends_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |=> req_ready_o);

  a_r9_nop_zero_address: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_NOP) |-> (addr_o == '0 && ba_o == '0));

  a_r10_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (cmd_o == CMD_NOP && !dq_oe_o && dqm_o == '0));
endmodule

bind sdram_wr_intr_seq sdw_chk #(
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .DQM_W  (DQM_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready_o (req_ready_o),
  .cmd_o       (cmd_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dq_oe_o     (dq_oe_o),
  .dqm_o       (dqm_o)
);

// File: tb/tb_sdram_wr_intr_seq.sv
module tb_sdram_wr_intr_seq;
  localparam int BURST = 4;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cas_lat_i;
  logic [2:0]  wr_rec_i, trp_i;
  logic        req_valid_i, req_ready_o, req_kind_i, req_all_i;
  logic [1:0]  req_bank_i;
  logic [7:0]  req_wcol_i, req_rcol_i;
  logic [11:0] req_row_i;
  logic [2:0]  req_len_i;
  logic [2:0]  cmd_o;
  logic [1:0]  ba_o;
  logic [11:0] addr_o;
  logic        dq_oe_o;
  logic [1:0]  dqm_o;

  sdram_wr_intr_seq dut (
    .clk(clk), .rst_n(rst_n), .cas_lat_i(cas_lat_i), .wr_rec_i(wr_rec_i), .trp_i(trp_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_kind_i(req_kind_i),
    .req_all_i(req_all_i), .req_bank_i(req_bank_i), .req_wcol_i(req_wcol_i),
    .req_rcol_i(req_rcol_i), .req_row_i(req_row_i), .req_len_i(req_len_i),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    bit          oe;
    bit          dqm;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    nchk = 0;
  int    nerr = 0;
  bit    model_ready = 1'b1;
  string scen = "-";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] %s act=%0h exp=%0h t=%0t", tag, scen, what, act, expv, $time);
    end
  endtask

  // reference schedule, computed from the requirements
  task automatic push_sched();
    int L, C, M, T, last, pre;
    L = (req_len_i == 0) ? 1 : ((req_len_i > BURST) ? BURST : int'(req_len_i));
    C = (cas_lat_i == 0) ? 1 : int'(cas_lat_i);
    M = (wr_rec_i == 0) ? 1 : int'(wr_rec_i);
    T = (trp_i == 0) ? 1 : int'(trp_i);
    pre  = L - 1 + M;
    last = req_kind_i ? pre + T : L + C + BURST - 1;
    for (int p = 0; p <= last; p++) begin
      exp_t e;
      e.cmd = 3'b111; e.ba = 0; e.addr = 0; e.tag = "R9";
      if (p == 0) begin
        e.cmd = 3'b100; e.ba = req_bank_i; e.addr = {4'h0, req_wcol_i}; e.tag = "R1";
      end else if (!req_kind_i && p == L) begin
        e.cmd = 3'b101; e.ba = req_bank_i; e.addr = {4'h0, req_rcol_i}; e.tag = "R2";
      end else if (req_kind_i && p == pre) begin
        e.cmd = 3'b010; e.ba = req_bank_i; e.addr = 12'(req_all_i) << 10; e.tag = "R5";
      end else if (req_kind_i && p == pre + T) begin
        e.cmd = 3'b011; e.ba = req_bank_i; e.addr = req_row_i; e.tag = "R7";
      end else if (!req_kind_i && p > L) begin
        e.tag = "R4";
      end
      e.oe  = (p < L);
      e.dqm = req_kind_i && (L < BURST) && (p >= L) && (p <= pre);
      exp_q.push_back(e);
    end
  endtask

  task automatic step();
    exp_t e;
    bit   busy_now;
    if (req_valid_i && model_ready && rst_n) push_sched();
    @(negedge clk);
    busy_now = (exp_q.size() != 0);
    if (busy_now) e = exp_q.pop_front();
    else begin
      e.cmd = 3'b111; e.ba = 0; e.addr = 0; e.oe = 0; e.dqm = 0; e.tag = "R9";
    end
    chk(req_ready_o == !busy_now, rst_n ? "R10" : "R11", "ready", req_ready_o, !busy_now);
    chk(cmd_o == e.cmd, e.tag, "cmd", cmd_o, e.cmd);
    chk(addr_o == e.addr && ba_o == e.ba, e.tag, "ba/addr", {ba_o, addr_o}, {e.ba, e.addr});
    chk(dq_oe_o == e.oe, rst_n ? "R3" : "R11", "dq_oe", dq_oe_o, e.oe);
    chk(dqm_o == {2{e.dqm}}, rst_n ? "R6" : "R11", "dqm", dqm_o, {2{e.dqm}});
    model_ready = !busy_now;
  endtask

  task automatic set_req(input bit kind, input bit all, input int bank, input int len,
                         input int cl, input int m, input int trp);
    req_kind_i = kind;      req_all_i  = all;       req_bank_i = 2'(bank);
    req_wcol_i = 8'(8'h30 + len + bank);  req_rcol_i = 8'(8'hA0 + cl);
    req_row_i  = 12'(12'h5C0 + m * 16 + trp);
    req_len_i  = 3'(len);
    cas_lat_i  = 2'(cl);    wr_rec_i   = 3'(m);     trp_i      = 3'(trp);
    req_valid_i = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step();
    step();
  endtask

  task automatic one(input bit kind, input bit all, input int bank, input int len,
                     input int cl, input int m, input int trp);
    set_req(kind, all, bank, len, cl, m, trp);
    step();
    req_valid_i = 1'b0;
    drain();
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid_i = 0; req_kind_i = 0; req_all_i = 0; req_bank_i = 0;
    req_wcol_i = 0; req_rcol_i = 0; req_row_i = 0; req_len_i = 1;
    cas_lat_i = 1; wr_rec_i = 1; trp_i = 1;
    scen = "R11";
    step(); step(); step();
    rst_n = 1'b1;
    step(); step();

    // R2 R3 R4: read interrupt, all lengths and latencies
    scen = "R2";
    for (int cl = 1; cl <= 3; cl++)
      for (int len = 1; len <= 4; len++)
        one(1'b0, 1'b0, (cl + len) % 4, len, cl, 2, 2);

    // R5 R6 R7: precharge interrupt
    scen = "R5";
    one(1'b1, 1'b0, 1, 2, 2, 2, 3);
    one(1'b1, 1'b0, 2, 4, 3, 3, 2);  // full burst: no mask
    one(1'b1, 1'b0, 3, 1, 1, 1, 1);  // PRE in first masked cycle
    one(1'b1, 1'b1, 0, 3, 2, 4, 7);  // precharge all
    one(1'b1, 1'b0, 2, 3, 2, 7, 5);

    // R8: clamping
    scen = "R8";
    one(1'b0, 1'b0, 1, 0, 0, 3, 3);
    one(1'b1, 1'b0, 2, 7, 2, 0, 0);
    one(1'b1, 1'b0, 3, 0, 1, 0, 4);

    // R10: valid held while busy; fields change mid-sequence
    scen = "R10";
    set_req(1'b1, 1'b0, 1, 2, 2, 3, 2);
    step();
    set_req(1'b0, 1'b0, 2, 3, 3, 1, 1);
    repeat (3) step();
    set_req(1'b0, 1'b0, 3, 1, 1, 5, 5);
    while (exp_q.size() != 0) step();
    step();      // idle cycle with valid still high: accepted at next edge
    req_valid_i = 1'b0;
    drain();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule